// File: doc/BRIEF.md
# ISA-to-Microcontroller Mailbox Bridge

This block links an 8-bit ISA I/O slave port to the external-memory bus of an 8-bit microcontroller. Each direction has a one-byte mailbox. The PC reaches the bridge through two I/O ports: a data port and, one address above it, a status port whose two low bits act as handshake flags. The microcontroller uses the two top bits of its address to pick between a write location and a read location. The block raises an active-low interrupt toward the microcontroller whenever the PC has left a byte for it.

A typical exchange runs like this. The microcontroller writes a byte, and the PC polls the "byte available" flag until it is set, then reads the data port, which clears the flag. In the other direction, the PC writes the data port, and this pulls the interrupt low. The microcontroller's interrupt routine reads the byte, which releases the interrupt and sets the "byte taken" flag. The PC waits for that flag before it writes again. All strobes are sampled on one clock. A strobe acts once, in the first cycle it is seen, however long it is then held. Tri-state buses are split into separate input, output and output-enable signals.

Top module: `isa_mcu_mailbox`

## Requirements
- R1: The data port answers only at the full 10-bit I/O address DATA_PORT (default 0x220), and the status port only at DATA_PORT+1 (0x221). Any other address, including one that differs only in bit 9, changes no state and enables no output.
- R2: While isa_aen is high, no ISA strobe is decoded: no state changes and isa_d_oe stays low.
- R3: A microcontroller write with mcu_addr_hi == 2'b10 latches mcu_d_in into the outbound register and sets status bit 0. Writes with any other mcu_addr_hi value are ignored.
- R4: An ISA read of the data port returns the outbound byte and clears status bit 0 one cycle after the read is first seen.
- R5: An ISA write of the data port latches isa_d_in into the inbound register, drives mcu_irq_n low and clears status bit 1.
- R6: A microcontroller read with mcu_addr_hi == 2'b01 returns the inbound byte, drives mcu_irq_n high and sets status bit 1.
- R7: A status-port read returns {6'b0, byte taken, byte available}, where bit 1 is "byte taken" and bit 0 is "byte available". Reading the status port has no side effect, and writing it is ignored.
- R8: A strobe held active over several cycles acts only once, in its first active cycle. A held microcontroller write keeps the byte present in that first cycle.
- R9: While isa_rst is high, at the next clock edge both registers and both flags are cleared and mcu_irq_n goes high.
- R10: isa_d_oe is high only during a decoded ISA read of either port, and mcu_d_oe only during a decoded microcontroller read. While the matching enable is low, the data output is zero.
- R11: If a write and a read of the same mailbox are first seen in the same cycle, the write wins. The flags end up as if the write came after the read.
- R12: The synchronous active-low rst_n leaves every register and flag cleared and mcu_irq_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| isa_rst | input | 1 | ISA bus reset, active high, synchronous clear |
| isa_addr | input | 10 | ISA I/O address |
| isa_aen | input | 1 | DMA address enable; high blocks decoding |
| isa_ior_n | input | 1 | ISA I/O read strobe, active low |
| isa_iow_n | input | 1 | ISA I/O write strobe, active low |
| isa_d_in | input | 8 | ISA data bus, inbound side |
| isa_d_out | output | 8 | ISA data bus, driven side |
| isa_d_oe | output | 1 | ISA data bus output enable |
| mcu_addr_hi | input | 2 | Microcontroller address bits [15:14] |
| mcu_rd_n | input | 1 | Microcontroller read strobe, active low |
| mcu_wr_n | input | 1 | Microcontroller write strobe, active low |
| mcu_d_in | input | 8 | Microcontroller data bus, inbound side |
| mcu_d_out | output | 8 | Microcontroller data bus, driven side |
| mcu_d_oe | output | 1 | Microcontroller data bus output enable |
| mcu_irq_n | output | 1 | Interrupt request to the microcontroller, active low |

## Verification
The bench builds the bridge with its default parameters: data port 0x220, status port 0x221, write region 2'b10 and read region 2'b01. With these values the decoder can be probed at its exact boundaries: the neighbouring port 0x222, the alias 0x020 that differs only in bit 9, and the two unused microcontroller regions. A random phase, compared cycle by cycle against a behavioural model, covers held strobes, collisions between a write and a read of the same mailbox, and ISA reset landing in the middle of a handshake.

// File: rtl/mbx_pkg.sv
// Package: shared constants for the ISA/microcontroller mailbox bridge.
// Assumes one byte per mailbox and the status layout below.
package mbx_pkg;
    localparam int STAT_AVAIL_BIT = 0;   // outbound byte waiting for the PC
    localparam int STAT_TAKEN_BIT = 1;   // inbound byte fetched by the MCU

    // Indices of the four decoded strobes in the edge-detector vector
    localparam int STB_ISA_WR = 0;
    localparam int STB_ISA_RD = 1;
    localparam int STB_MCU_WR = 2;
    localparam int STB_MCU_RD = 3;
    localparam int STB_COUNT  = 4;
endpackage

// File: rtl/mbx_decode.sv
// Module: mbx_decode
// Purely combinational address and strobe decoding for both buses.
// Assumes active-low strobes and a full-width match on the ISA address.
module mbx_decode #(
    parameter int              ISA_AW    = 10,
    parameter logic [ISA_AW-1:0] DATA_PORT = 10'h220,
    parameter int              MCU_SW    = 2,
    parameter logic [MCU_SW-1:0] MCU_WR_REGION = 2'b10,
    parameter logic [MCU_SW-1:0] MCU_RD_REGION = 2'b01
) (
    input  logic [ISA_AW-1:0] isa_addr,
    input  logic              isa_aen,
    input  logic              isa_ior_n,
    input  logic              isa_iow_n,
    input  logic [MCU_SW-1:0] mcu_addr_hi,
    input  logic              mcu_rd_n,
    input  logic              mcu_wr_n,
    output logic              isa_data_rd,
    output logic              isa_data_wr,
    output logic              isa_stat_rd,
    output logic              mcu_wr,
    output logic              mcu_rd
);
    localparam logic [ISA_AW-1:0] STAT_PORT = DATA_PORT + 1'b1;

    logic hit_data;
    logic hit_stat;

    // ISA port match, suppressed during DMA cycles
    always_comb begin
        hit_data    = !isa_aen && (isa_addr == DATA_PORT);
        hit_stat    = !isa_aen && (isa_addr == STAT_PORT);
        isa_data_rd = hit_data && !isa_ior_n;
        isa_data_wr = hit_data && !isa_iow_n;
        isa_stat_rd = hit_stat && !isa_ior_n;
    end

    // Microcontroller region match on the top address bits
    always_comb begin
        mcu_wr = (mcu_addr_hi == MCU_WR_REGION) && !mcu_wr_n;
        mcu_rd = (mcu_addr_hi == MCU_RD_REGION) && !mcu_rd_n;
    end
endmodule

// File: rtl/mbx_strobe_edge.sv
// Module: mbx_strobe_edge
// Turns a decoded strobe level into a one-cycle event in its first active
// cycle. Assumes the strobe is already synchronous to clk.
module mbx_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic lvl,
    output logic evt
);
    logic lvl_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n || clr) lvl_q <= 1'b0;
        else               lvl_q <= lvl;
    end

    // Event on the first active cycle only
    always_comb evt = lvl && !lvl_q;

    // R8
    single_evt_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        evt |=> !evt);
endmodule

// File: rtl/mbx_slot.sv
// Module: mbx_slot
// One-byte mailbox: a data register and a full flag. A write loads the data
// and sets full; a read clears full; a write wins a same-cycle collision.
// Assumes wr_evt and rd_evt are single-cycle events.
module mbx_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_evt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_evt,
    output logic [DATA_W-1:0] data,
    output logic              full
);
    // Data register, loaded by a write
    always_ff @(posedge clk) begin
        if (!rst_n || clr) data <= '0;
        else if (wr_evt)   data <= wr_data;
    end

    // Full flag: write sets, read clears, write has priority
    always_ff @(posedge clk) begin
        if (!rst_n || clr) full <= 1'b0;
        else if (wr_evt)   full <= 1'b1;
        else if (rd_evt)   full <= 1'b0;
    end

    // R3
    latch_data_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        wr_evt |=> (data == $past(wr_data)));
    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (wr_evt && rd_evt) |=> full);
    // R4
    read_drains_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (rd_evt && !wr_evt) |=> !full);
    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !wr_evt |=> $stable(data));
endmodule

// File: rtl/isa_mcu_mailbox.sv
// Module: isa_mcu_mailbox
// Top level of the two-mailbox bridge between an ISA I/O slave and a
// microcontroller memory bus. Wait-state generation lives elsewhere.
// Assumes all bus strobes are synchronous to clk.
module isa_mcu_mailbox
    import mbx_pkg::*;
#(
    parameter int                ISA_AW        = 10,
    parameter logic [ISA_AW-1:0] DATA_PORT     = 10'h220,
    parameter int                MCU_SW        = 2,
    parameter logic [MCU_SW-1:0] MCU_WR_REGION = 2'b10,
    parameter logic [MCU_SW-1:0] MCU_RD_REGION = 2'b01,
    parameter int                DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              isa_rst,
    input  logic [ISA_AW-1:0] isa_addr,
    input  logic              isa_aen,
    input  logic              isa_ior_n,
    input  logic              isa_iow_n,
    input  logic [DATA_W-1:0] isa_d_in,
    output logic [DATA_W-1:0] isa_d_out,
    output logic              isa_d_oe,
    input  logic [MCU_SW-1:0] mcu_addr_hi,
    input  logic              mcu_rd_n,
    input  logic              mcu_wr_n,
    input  logic [DATA_W-1:0] mcu_d_in,
    output logic [DATA_W-1:0] mcu_d_out,
    output logic              mcu_d_oe,
    output logic              mcu_irq_n
);
    localparam int PAD_W = DATA_W - 2;

    logic isa_data_rd, isa_data_wr, isa_stat_rd, mcu_wr, mcu_rd;
    logic [STB_COUNT-1:0] stb_lvl;
    logic [STB_COUNT-1:0] stb_evt;
    logic [DATA_W-1:0] ob_data, ib_data;
    logic ob_full, ib_full, ib_taken;
    logic [DATA_W-1:0] status;

    mbx_decode #(
        .ISA_AW(ISA_AW), .DATA_PORT(DATA_PORT), .MCU_SW(MCU_SW),
        .MCU_WR_REGION(MCU_WR_REGION), .MCU_RD_REGION(MCU_RD_REGION)
    ) u_decode (
        .isa_addr(isa_addr), .isa_aen(isa_aen),
        .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n),
        .mcu_addr_hi(mcu_addr_hi), .mcu_rd_n(mcu_rd_n), .mcu_wr_n(mcu_wr_n),
        .isa_data_rd(isa_data_rd), .isa_data_wr(isa_data_wr),
        .isa_stat_rd(isa_stat_rd), .mcu_wr(mcu_wr), .mcu_rd(mcu_rd)
    );

    // Gather the strobes that carry side effects
    always_comb begin
        stb_lvl             = '0;
        stb_lvl[STB_ISA_WR] = isa_data_wr;
        stb_lvl[STB_ISA_RD] = isa_data_rd;
        stb_lvl[STB_MCU_WR] = mcu_wr;
        stb_lvl[STB_MCU_RD] = mcu_rd;
    end

    for (genvar i = 0; i < STB_COUNT; i++) begin : g_edge
        mbx_strobe_edge u_edge (
            .clk(clk), .rst_n(rst_n), .clr(isa_rst),
            .lvl(stb_lvl[i]), .evt(stb_evt[i])
        );
    end

    // Outbound: microcontroller to PC
    mbx_slot #(.DATA_W(DATA_W)) u_outbound (
        .clk(clk), .rst_n(rst_n), .clr(isa_rst),
        .wr_evt(stb_evt[STB_MCU_WR]), .wr_data(mcu_d_in),
        .rd_evt(stb_evt[STB_ISA_RD]),
        .data(ob_data), .full(ob_full)
    );

    // Inbound: PC to microcontroller
    mbx_slot #(.DATA_W(DATA_W)) u_inbound (
        .clk(clk), .rst_n(rst_n), .clr(isa_rst),
        .wr_evt(stb_evt[STB_ISA_WR]), .wr_data(isa_d_in),
        .rd_evt(stb_evt[STB_MCU_RD]),
        .data(ib_data), .full(ib_full)
    );

    // Taken flag: set by the MCU read, cleared by a new PC write (write wins)
    always_ff @(posedge clk) begin
        if (!rst_n || isa_rst)         ib_taken <= 1'b0;
        else if (stb_evt[STB_ISA_WR])  ib_taken <= 1'b0;
        else if (stb_evt[STB_MCU_RD])  ib_taken <= 1'b1;
    end

    // Status byte assembly
    always_comb begin
        status                 = '0;
        status[STAT_AVAIL_BIT] = ob_full;
        status[STAT_TAKEN_BIT] = ib_taken;
    end

    // ISA read mux and enable
    always_comb begin
        isa_d_oe  = isa_data_rd || isa_stat_rd;
        isa_d_out = isa_data_rd ? ob_data : (isa_stat_rd ? status : '0);
    end

    // Microcontroller read mux, enable and interrupt
    always_comb begin
        mcu_d_oe  = mcu_rd;
        mcu_d_out = mcu_rd ? ib_data : '0;
        mcu_irq_n = !ib_full;
    end

    // R2
    aen_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_aen |-> !isa_d_oe);
    // R10
    isa_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_d_oe |-> !isa_ior_n);
    // R10
    mcu_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mcu_d_oe |-> (!mcu_rd_n && mcu_addr_hi == MCU_RD_REGION));
    // R9
    isa_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_rst |=> (mcu_irq_n && !ob_full && !ib_taken));
    // R5
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n || isa_rst)
        $fell(mcu_irq_n) |-> $past(stb_evt[STB_ISA_WR]));
    // R6
    taken_set_chk: assert property (@(posedge clk) disable iff (!rst_n || isa_rst)
        (stb_evt[STB_MCU_RD] && !stb_evt[STB_ISA_WR]) |=> (ib_taken && mcu_irq_n));
    // R7
    stat_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (isa_stat_rd && isa_d_oe) |-> (isa_d_out[DATA_W-1:2] == PAD_W'(0)));
endmodule

// File: tb/isa_mcu_mailbox_tb.sv
module isa_mcu_mailbox_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       isa_rst = 1'b0;
    logic [9:0] isa_addr = '0;
    logic       isa_aen = 1'b0;
    logic       isa_ior_n = 1'b1;
    logic       isa_iow_n = 1'b1;
    logic [7:0] isa_d_in = '0;
    logic [7:0] isa_d_out;
    logic       isa_d_oe;
    logic [1:0] mcu_addr_hi = '0;
    logic       mcu_rd_n = 1'b1;
    logic       mcu_wr_n = 1'b1;
    logic [7:0] mcu_d_in = '0;
    logic [7:0] mcu_d_out;
    logic       mcu_d_oe;
    logic       mcu_irq_n;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    isa_mcu_mailbox u_dut (
        .clk(clk), .rst_n(rst_n), .isa_rst(isa_rst),
        .isa_addr(isa_addr), .isa_aen(isa_aen),
        .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n),
        .isa_d_in(isa_d_in), .isa_d_out(isa_d_out), .isa_d_oe(isa_d_oe),
        .mcu_addr_hi(mcu_addr_hi), .mcu_rd_n(mcu_rd_n), .mcu_wr_n(mcu_wr_n),
        .mcu_d_in(mcu_d_in), .mcu_d_out(mcu_d_out), .mcu_d_oe(mcu_d_oe),
        .mcu_irq_n(mcu_irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ob = 0, m_ib = 0;
    bit m_avail = 0, m_ibfull = 0, m_taken = 0;
    bit p_iw = 0, p_ir = 0, p_mw = 0, p_mr = 0;

    function automatic bit hit(input int port);
        return (isa_aen == 1'b0) && (int'(isa_addr) == port);
    endfunction

    always @(posedge clk) begin
        bit iw, ir, mw, mr;
        iw = hit(32'h220) && !isa_iow_n;
        ir = hit(32'h220) && !isa_ior_n;
        mw = (mcu_addr_hi == 2'b10) && !mcu_wr_n;
        mr = (mcu_addr_hi == 2'b01) && !mcu_rd_n;
        if (!rst_n || isa_rst) begin
            m_ob = 0; m_ib = 0; m_avail = 0; m_ibfull = 0; m_taken = 0;
            p_iw = 0; p_ir = 0; p_mw = 0; p_mr = 0;
        end else begin
            if (ir && !p_ir) m_avail = 0;
            if (mw && !p_mw) begin m_ob = int'(mcu_d_in); m_avail = 1; end
            if (mr && !p_mr) begin m_ibfull = 0; m_taken = 1; end
            if (iw && !p_iw) begin m_ib = int'(isa_d_in); m_ibfull = 1; m_taken = 0; end
            p_iw = iw; p_ir = ir; p_mw = mw; p_mr = mr;
        end
        started <= 1;
    end

    // Compare every output against the model, mid-cycle
    always @(negedge clk) begin
        if (started && !done) begin
            bit drd, srd, mrd;
            int exp_isa, exp_mcu;
            drd = hit(32'h220) && !isa_ior_n;
            srd = hit(32'h221) && !isa_ior_n;
            mrd = (mcu_addr_hi == 2'b01) && !mcu_rd_n;
            exp_isa = drd ? m_ob : (srd ? ((int'(m_taken) << 1) | int'(m_avail)) : 0);
            exp_mcu = mrd ? m_ib : 0;
            chk("R10 model isa_d_oe", int'(isa_d_oe), int'(drd || srd));
            chk("R7 model isa_d_out", int'(isa_d_out), exp_isa);
            chk("R10 model mcu_d_oe", int'(mcu_d_oe), int'(mrd));
            chk("R6 model mcu_d_out", int'(mcu_d_out), exp_mcu);
            chk("R5 model mcu_irq_n", int'(mcu_irq_n), int'(!m_ibfull));
        end
    end

    // ---------------- bus tasks ----------------
    task automatic mcu_write(input logic [1:0] hi, input logic [7:0] d);
        @(posedge clk); #2;
        mcu_addr_hi = hi; mcu_d_in = d; mcu_wr_n = 1'b0;
        @(posedge clk); #2;
        mcu_wr_n = 1'b1;
    endtask

    task automatic mcu_read(input logic [1:0] hi, output int d, output int oe);
        @(posedge clk); #2;
        mcu_addr_hi = hi; mcu_rd_n = 1'b0;
        @(negedge clk);
        d = int'(mcu_d_out); oe = int'(mcu_d_oe);
        @(posedge clk); #2;
        mcu_rd_n = 1'b1;
    endtask

    task automatic isa_write(input logic [9:0] a, input logic aen, input logic [7:0] d);
        @(posedge clk); #2;
        isa_addr = a; isa_aen = aen; isa_d_in = d; isa_iow_n = 1'b0;
        @(posedge clk); #2;
        isa_iow_n = 1'b1; isa_aen = 1'b0;
    endtask

    task automatic isa_read(input logic [9:0] a, input logic aen, output int d, output int oe);
        @(posedge clk); #2;
        isa_addr = a; isa_aen = aen; isa_ior_n = 1'b0;
        @(negedge clk);
        d = int'(isa_d_out); oe = int'(isa_d_oe);
        @(posedge clk); #2;
        isa_ior_n = 1'b1; isa_aen = 1'b0;
    endtask

    task automatic status(output int s);
        int oe;
        isa_read(10'h221, 1'b0, s, oe);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int d, oe, s;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 irq after reset", int'(mcu_irq_n), 1);
        status(s);
        chk("R12 status after reset", s, 0);

        // R3 / R4 outbound handshake
        mcu_write(2'b10, 8'hA5);
        status(s);
        chk("R3 avail set", s & 1, 1);
        isa_read(10'h220, 1'b0, d, oe);
        chk("R4 data read", d, 32'hA5);
        chk("R10 oe on data read", oe, 1);
        status(s);
        chk("R4 avail cleared", s & 1, 0);

        // R5 / R6 inbound handshake
        isa_write(10'h220, 1'b0, 8'h3C);
        @(negedge clk);
        chk("R5 irq asserted", int'(mcu_irq_n), 0);
        status(s);
        chk("R5 taken clear", s & 2, 0);
        mcu_read(2'b01, d, oe);
        chk("R6 inbound byte", d, 32'h3C);
        chk("R10 mcu oe", oe, 1);
        @(negedge clk);
        chk("R6 irq released", int'(mcu_irq_n), 1);
        status(s);
        chk("R6 taken set", s, 2);

        // R2 DMA cycles ignored
        isa_write(10'h220, 1'b1, 8'h77);
        @(negedge clk);
        chk("R2 aen write ignored", int'(mcu_irq_n), 1);
        isa_read(10'h221, 1'b1, d, oe);
        chk("R2 aen read no oe", oe, 0);

        // R1 near-miss addresses
        isa_write(10'h222, 1'b0, 8'h11);
        isa_write(10'h020, 1'b0, 8'h22);
        @(negedge clk);
        chk("R1 near-miss writes ignored", int'(mcu_irq_n), 1);
        isa_read(10'h020, 1'b0, d, oe);
        chk("R1 alias read no oe", oe, 0);
        chk("R10 data zero when disabled", d, 0);

        // R3 other microcontroller regions ignored
        mcu_write(2'b11, 8'h99);
        mcu_write(2'b00, 8'h98);
        status(s);
        chk("R3 other regions ignored", s, 2);
        mcu_read(2'b00, d, oe);
        chk("R10 mcu oe outside region", oe, 0);

        // R7 status read has no side effect; status write ignored
        mcu_write(2'b10, 8'h5A);
        status(s); status(s);
        chk("R7 repeat status read", s, 3);
        isa_write(10'h221, 1'b0, 8'hFF);
        status(s);
        chk("R7 status write ignored", s, 3);
        chk("R7 status write no irq", int'(mcu_irq_n), 1);
        isa_read(10'h220, 1'b0, d, oe);
        chk("R7 byte intact", d, 32'h5A);

        // R8 held write keeps its first byte
        @(posedge clk); #2;
        mcu_addr_hi = 2'b10; mcu_d_in = 8'h01; mcu_wr_n = 1'b0;
        for (int i = 2; i < 6; i++) begin
            @(posedge clk); #2; mcu_d_in = 8'(i);
        end
        mcu_wr_n = 1'b1;
        isa_read(10'h220, 1'b0, d, oe);
        chk("R8 held write first byte", d, 1);
        // R8 held ISA read clears the flag once; a new MCU write during it sticks
        @(posedge clk); #2;
        isa_addr = 10'h220; isa_ior_n = 1'b0;
        @(posedge clk); #2;
        mcu_addr_hi = 2'b10; mcu_d_in = 8'hC3; mcu_wr_n = 1'b0;
        @(posedge clk); #2;
        mcu_wr_n = 1'b1;
        @(posedge clk); #2;
        isa_ior_n = 1'b1;
        status(s);
        chk("R8 held read acts once", s & 1, 1);

        // R11 collision: MCU write and ISA read in the same first cycle
        isa_read(10'h220, 1'b0, d, oe);
        @(posedge clk); #2;
        isa_addr = 10'h220; isa_ior_n = 1'b0;
        mcu_addr_hi = 2'b10; mcu_d_in = 8'h66; mcu_wr_n = 1'b0;
        @(posedge clk); #2;
        isa_ior_n = 1'b1; mcu_wr_n = 1'b1;
        status(s);
        chk("R11 outbound write wins", s & 1, 1);
        // R11 collision on the inbound side
        @(posedge clk); #2;
        isa_addr = 10'h220; isa_d_in = 8'h44; isa_iow_n = 1'b0;
        mcu_addr_hi = 2'b01; mcu_rd_n = 1'b0;
        @(posedge clk); #2;
        isa_iow_n = 1'b1; mcu_rd_n = 1'b1;
        @(negedge clk);
        chk("R11 inbound write wins irq", int'(mcu_irq_n), 0);
        status(s);
        chk("R11 inbound write wins taken", s & 2, 0);

        // R9 ISA reset clears everything
        @(posedge clk); #2 isa_rst = 1'b1;
        @(posedge clk); #2 isa_rst = 1'b0;
        @(negedge clk);
        chk("R9 irq released", int'(mcu_irq_n), 1);
        status(s);
        chk("R9 flags cleared", s, 0);
        isa_read(10'h220, 1'b0, d, oe);
        chk("R9 outbound cleared", d, 0);
        mcu_read(2'b01, d, oe);
        chk("R9 inbound cleared", d, 0);

        // Random traffic against the model (R1..R11)
        for (int n = 0; n < 3000; n++) begin
            int r;
            @(posedge clk); #2;
            r = int'($urandom_range(0, 3));
            isa_addr    = (r == 0) ? 10'h221 : (r == 1) ? 10'h020 : 10'h220;
            isa_aen     = ($urandom_range(0, 9) == 0);
            isa_ior_n   = $urandom_range(0, 2) != 0;
            isa_iow_n   = $urandom_range(0, 2) != 0;
            isa_d_in    = 8'($urandom);
            mcu_addr_hi = 2'($urandom);
            mcu_rd_n    = $urandom_range(0, 2) != 0;
            mcu_wr_n    = $urandom_range(0, 2) != 0;
            mcu_d_in    = 8'($urandom);
            isa_rst     = ($urandom_range(0, 99) == 0);
        end
        @(posedge clk); #2;
        isa_ior_n = 1'b1; isa_iow_n = 1'b1; mcu_rd_n = 1'b1; mcu_wr_n = 1'b1;
        isa_rst = 1'b0; isa_aen = 1'b0;

        // R12 synchronous reset mid-traffic
        mcu_write(2'b10, 8'hEE);
        @(posedge clk); #2 rst_n = 1'b0;
        @(posedge clk); #2 rst_n = 1'b1;
        status(s);
        chk("R12 reset clears flags", s, 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule